// File: doc/BRIEF.md
# Tag-Broadcast Reservation Station Bank

This block holds the waiting operations for one functional-unit type in a dynamically scheduled core, together with the shared table that tracks which station will next write each architectural register. An issue request names two source registers, gives the register-file values for them, and names a destination register and an address word. The block then allocates a free station. Each source operand is stored either as a value or as the tag of the station that will produce it. The destination register is renamed to the new station's tag.

A result bus delivers one tag and one data word per cycle. Every waiting operand that holds that tag takes the data. The station that owns the tag is released, and the status-table entries that still point at it are cleared. When both operands of a station are present, the station may be sent to the functional unit. The lowest-numbered ready station goes first, and at most one station is sent per cycle. Renaming comes from the tags alone, so no separate rename file is needed. Station tags run from 1 to the station count. Tag 0 means "value present".

Top module: `rs_tag_bank`

## Requirements
- R1: After reset no station is occupied: `issueReady` is 1, `dispValid` is 0, and every status-table entry is empty, so the first operations issued take their operands from `issueValJ`/`issueValK`.
- R2: An issue with `issueValid` high and `issueReady` high takes the lowest-numbered free station, whose tag is its index plus one. `issueReady` is low exactly when all `NUM_RS` stations are occupied. An issue attempted while it is low has no effect.
- R3: A source register whose status entry is empty is captured from the issue value bus. If both sources are present, the station is offered on the dispatch port in the cycle after issue, with its operation code and address word.
- R4: Issue writes the new station's tag into the destination register's status entry. A later issue that reads that register waits on the tag and ignores the value offered on the issue bus.
- R5: A valid result broadcast with tag T writes its data into every waiting operand holding T. A station made ready by a broadcast is offered for dispatch in the following cycle, carrying the broadcast data.
- R6: When a broadcast and an issue that reads the broadcast tag occur in the same cycle, the issuing station takes the broadcast data directly and does not wait.
- R7: Among ready stations the lowest-numbered one is dispatched. At most one station is dispatched per cycle, and each station is dispatched once per allocation.
- R8: A broadcast with tag T frees station T in the same edge, so `issueReady` is high in the next cycle.
- R9: A broadcast clears a status entry only if the entry still holds the broadcast tag. An entry renamed to a newer station keeps that newer tag.
- R10: A broadcast with `cdbValid` low, or with tag 0, captures nothing and frees nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| issueValid | input | 1 | Issue request |
| issueOp | input | OP_W | Operation code to store |
| issueRegJ | input | REG_W | First source register index |
| issueValJ | input | DATA_W | Register-file value of first source |
| issueRegK | input | REG_W | Second source register index |
| issueValK | input | DATA_W | Register-file value of second source |
| issueDest | input | REG_W | Destination register index |
| issueAddr | input | ADDR_W | Address word kept with the operation |
| issueReady | output | 1 | A station is free this cycle |
| cdbValid | input | 1 | Result broadcast valid |
| cdbTag | input | 4 | Tag of the producing station |
| cdbData | input | DATA_W | Broadcast result value |
| dispValid | output | 1 | A ready station is being sent this cycle |
| dispTag | output | 4 | Tag of the dispatched station |
| dispOp | output | OP_W | Operation code of the dispatched station |
| dispVj | output | DATA_W | First operand value |
| dispVk | output | DATA_W | Second operand value |
| dispAddr | output | ADDR_W | Address word of the dispatched station |

## Verification
The hardest cases to reach from the ports combine timing with renaming. One is a broadcast landing in the same edge as an issue that reads the broadcasting tag. Another is a status entry that has been renamed again before its first producer broadcasts. A third is a result-bus cycle whose tag matches a waiting operand while its valid bit is low. Directed sequences fill every station, re-rename a register and then line up these edges exactly. The random phase acts as the functional unit and returns results after random delays. It drives junk on the issue value bus whenever a source is still pending, so a wrongly cleared tag or a missed bypass shows up as a wrong dispatched operand or as a station that never drains.

// File: rtl/rs_pkg.sv
package rs_pkg;
  // Tag width fixed by the result bus; tag 0 means "value present".
  localparam int TAG_W  = 4;
  localparam int MAX_RS = (1 << TAG_W) - 1;

  // Strobes from control to datapath. Slots are zero-based; tag = slot + 1.
  typedef struct packed {
    logic              alloc;
    logic [TAG_W-1:0]  allocSlot;
    logic              jFromBus;
    logic              kFromBus;
    logic [MAX_RS-1:0] capJ;
    logic [MAX_RS-1:0] capK;
    logic              disp;
    logic [TAG_W-1:0]  dispSlot;
  } rsStrobe_t;
endpackage

// File: rtl/rs_ctrl.sv
module rs_ctrl
  import rs_pkg::*;
#(
  parameter int NUM_RS   = 3,
  parameter int NUM_REGS = 8,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             issueValid,
  input  logic [REG_W-1:0] issueRegJ,
  input  logic [REG_W-1:0] issueRegK,
  input  logic [REG_W-1:0] issueDest,
  input  logic             cdbValid,
  input  logic [TAG_W-1:0] cdbTag,
  output logic             issueReady,
  output logic             dispValid,
  output logic [TAG_W-1:0] dispTag,
  output rsStrobe_t        strobe
);

  logic [NUM_RS-1:0] busy;
  logic [NUM_RS-1:0] started;
  logic [NUM_RS-1:0] readyVec;
  logic [TAG_W-1:0]  qj      [NUM_RS];
  logic [TAG_W-1:0]  qk      [NUM_RS];
  logic [TAG_W-1:0]  regStat [NUM_REGS];

  logic             busHit;
  logic             foundFree;
  logic             foundDisp;
  logic [TAG_W-1:0] freeSlot;
  logic [TAG_W-1:0] pickSlot;
  logic [TAG_W-1:0] tagJ;
  logic [TAG_W-1:0] tagK;
  logic [TAG_W-1:0] newQj;
  logic [TAG_W-1:0] newQk;

  always_comb begin
    busHit    = cdbValid && (cdbTag != '0);
    foundFree = 1'b0;
    freeSlot  = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (!busy[i] && !foundFree) begin
        foundFree = 1'b1;
        freeSlot  = TAG_W'(i);
      end
    end
    foundDisp = 1'b0;
    pickSlot  = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      readyVec[i] = busy[i] && !started[i] && (qj[i] == '0) && (qk[i] == '0);
      if (readyVec[i] && !foundDisp) begin
        foundDisp = 1'b1;
        pickSlot  = TAG_W'(i);
      end
    end
    tagJ = regStat[issueRegJ];
    tagK = regStat[issueRegK];

    strobe           = '0;
    strobe.alloc     = issueValid && foundFree;
    strobe.allocSlot = freeSlot;
    strobe.jFromBus  = busHit && (tagJ != '0) && (tagJ == cdbTag);
    strobe.kFromBus  = busHit && (tagK != '0) && (tagK == cdbTag);
    for (int i = 0; i < NUM_RS; i++) begin
      strobe.capJ[i] = busy[i] && busHit && (qj[i] == cdbTag);
      strobe.capK[i] = busy[i] && busHit && (qk[i] == cdbTag);
    end
    strobe.disp     = foundDisp;
    strobe.dispSlot = pickSlot;

    newQj = (strobe.jFromBus || tagJ == '0) ? '0 : tagJ;
    newQk = (strobe.kFromBus || tagK == '0) ? '0 : tagK;

    issueReady = foundFree;
    dispValid  = foundDisp;
    dispTag    = pickSlot + TAG_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= '0;
      started <= '0;
      for (int i = 0; i < NUM_RS; i++) begin
        qj[i] <= '0;
        qk[i] <= '0;
      end
      for (int r = 0; r < NUM_REGS; r++) regStat[r] <= '0;
    end else begin
      for (int i = 0; i < NUM_RS; i++) begin
        if (strobe.capJ[i]) qj[i] <= '0;
        if (strobe.capK[i]) qk[i] <= '0;
        if (strobe.disp && pickSlot == TAG_W'(i)) started[i] <= 1'b1;
        if (busHit && cdbTag == TAG_W'(i + 1)) busy[i] <= 1'b0;
        if (strobe.alloc && freeSlot == TAG_W'(i)) begin
          busy[i]    <= 1'b1;
          started[i] <= 1'b0;
          qj[i]      <= newQj;
          qk[i]      <= newQk;
        end
      end
      for (int r = 0; r < NUM_REGS; r++) begin
        if (busHit && regStat[r] == cdbTag) regStat[r] <= '0;
        if (strobe.alloc && issueDest == REG_W'(r)) regStat[r] <= freeSlot + TAG_W'(1);
      end
    end
  end

  // R2
  full_blocks_alloc_chk: assert property (@(posedge clk) disable iff (!rstN)
    !issueReady |=> ($countones(busy) <= $past($countones(busy))));

  // R7
  single_dispatch_chk: assert property (@(posedge clk) disable iff (!rstN)
    dispValid |=> !(dispValid && dispTag == $past(dispTag)));

  // R8
  bcast_frees_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cdbValid && cdbTag != '0 && cdbTag <= TAG_W'(NUM_RS) && !issueValid) |=> issueReady);

  // R9
  for (genvar r = 0; r < NUM_REGS; r++) begin : gStat
    for (genvar i = 0; i < NUM_RS; i++) begin : gSt
      stat_tracks_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
        (regStat[r] == TAG_W'(i + 1)) |-> busy[i]);
    end
  end

endmodule

// File: rtl/rs_data.sv
module rs_data
  import rs_pkg::*;
#(
  parameter int NUM_RS = 3,
  parameter int DATA_W = 64,
  parameter int OP_W   = 4,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  rsStrobe_t         strobe,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [DATA_W-1:0] issueValJ,
  input  logic [DATA_W-1:0] issueValK,
  input  logic [ADDR_W-1:0] issueAddr,
  input  logic [DATA_W-1:0] cdbData,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispVj,
  output logic [DATA_W-1:0] dispVk,
  output logic [ADDR_W-1:0] dispAddr
);

  logic [OP_W-1:0]   opQ   [NUM_RS];
  logic [DATA_W-1:0] vj    [NUM_RS];
  logic [DATA_W-1:0] vk    [NUM_RS];
  logic [ADDR_W-1:0] addrQ [NUM_RS];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_RS; i++) begin
        opQ[i]   <= '0;
        vj[i]    <= '0;
        vk[i]    <= '0;
        addrQ[i] <= '0;
      end
    end else begin
      for (int i = 0; i < NUM_RS; i++) begin
        if (strobe.alloc && strobe.allocSlot == TAG_W'(i)) begin
          opQ[i]   <= issueOp;
          addrQ[i] <= issueAddr;
          vj[i]    <= strobe.jFromBus ? cdbData : issueValJ;
          vk[i]    <= strobe.kFromBus ? cdbData : issueValK;
        end else begin
          if (strobe.capJ[i]) vj[i] <= cdbData;
          if (strobe.capK[i]) vk[i] <= cdbData;
        end
      end
    end
  end

  always_comb begin
    dispOp   = '0;
    dispVj   = '0;
    dispVk   = '0;
    dispAddr = '0;
    for (int i = 0; i < NUM_RS; i++) begin
      if (strobe.disp && strobe.dispSlot == TAG_W'(i)) begin
        dispOp   = opQ[i];
        dispVj   = vj[i];
        dispVk   = vk[i];
        dispAddr = addrQ[i];
      end
    end
  end

  // R5
  for (genvar i = 0; i < NUM_RS; i++) begin : gCap
    cap_value_chk: assert property (@(posedge clk) disable iff (!rstN)
      strobe.capJ[i] |=> (vj[i] == $past(cdbData)));
  end

endmodule

// File: rtl/rs_tag_bank.sv
module rs_tag_bank
  import rs_pkg::*;
#(
  parameter int NUM_RS   = 3,
  parameter int NUM_REGS = 8,
  parameter int DATA_W   = 64,
  parameter int OP_W     = 4,
  parameter int ADDR_W   = 16,
  localparam int REG_W   = $clog2(NUM_REGS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              issueValid,
  input  logic [OP_W-1:0]   issueOp,
  input  logic [REG_W-1:0]  issueRegJ,
  input  logic [DATA_W-1:0] issueValJ,
  input  logic [REG_W-1:0]  issueRegK,
  input  logic [DATA_W-1:0] issueValK,
  input  logic [REG_W-1:0]  issueDest,
  input  logic [ADDR_W-1:0] issueAddr,
  output logic              issueReady,
  input  logic              cdbValid,
  input  logic [3:0]        cdbTag,
  input  logic [DATA_W-1:0] cdbData,
  output logic              dispValid,
  output logic [3:0]        dispTag,
  output logic [OP_W-1:0]   dispOp,
  output logic [DATA_W-1:0] dispVj,
  output logic [DATA_W-1:0] dispVk,
  output logic [ADDR_W-1:0] dispAddr
);

  rsStrobe_t strobe;

  rs_ctrl #(.NUM_RS(NUM_RS), .NUM_REGS(NUM_REGS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueRegJ(issueRegJ), .issueRegK(issueRegK),
    .issueDest(issueDest), .cdbValid(cdbValid), .cdbTag(cdbTag),
    .issueReady(issueReady), .dispValid(dispValid), .dispTag(dispTag),
    .strobe(strobe)
  );

  rs_data #(.NUM_RS(NUM_RS), .DATA_W(DATA_W), .OP_W(OP_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .issueOp(issueOp), .issueValJ(issueValJ), .issueValK(issueValK),
    .issueAddr(issueAddr), .cdbData(cdbData),
    .dispOp(dispOp), .dispVj(dispVj), .dispVk(dispVk), .dispAddr(dispAddr)
  );

endmodule

// File: tb/sim_rs_tag_bank.sv
module sim_rs_tag_bank;
  localparam int CLK_PERIOD  = 10;
  localparam int NRS         = 3;
  localparam int NREG        = 8;
  localparam int RAND_CYCLES = 3000;
  localparam int DRAIN       = 400;
  localparam logic [63:0] JUNK = 64'd999;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        issueValid = 1'b0;
  logic [3:0]  issueOp = '0;
  logic [2:0]  issueRegJ = '0, issueRegK = '0, issueDest = '0;
  logic [63:0] issueValJ = '0, issueValK = '0;
  logic [15:0] issueAddr = '0;
  logic        issueReady;
  logic        cdbValid = 1'b0;
  logic [3:0]  cdbTag = '0;
  logic [63:0] cdbData = '0;
  logic        dispValid;
  logic [3:0]  dispTag;
  logic [3:0]  dispOp;
  logic [63:0] dispVj, dispVk;
  logic [15:0] dispAddr;

  int total = 0;
  int bad = 0;

  logic [63:0] rf [NREG];
  logic [63:0] gold [NREG];
  int          regWriter [NREG];
  logic [63:0] expJ [NRS+1];
  logic [63:0] expK [NRS+1];
  logic [3:0]  expOp [NRS+1];
  logic [15:0] expAddr [NRS+1];
  logic [63:0] pendData [NRS+1];
  int          pendDelay [NRS+1];
  bit          mBusy [NRS+1];
  bit          mStarted [NRS+1];
  bit          pend [NRS+1];

  always #(CLK_PERIOD/2) clk = ~clk;

  rs_tag_bank u0 (
    .clk(clk), .rstN(rstN),
    .issueValid(issueValid), .issueOp(issueOp), .issueRegJ(issueRegJ),
    .issueValJ(issueValJ), .issueRegK(issueRegK), .issueValK(issueValK),
    .issueDest(issueDest), .issueAddr(issueAddr), .issueReady(issueReady),
    .cdbValid(cdbValid), .cdbTag(cdbTag), .cdbData(cdbData),
    .dispValid(dispValid), .dispTag(dispTag), .dispOp(dispOp),
    .dispVj(dispVj), .dispVk(dispVk), .dispAddr(dispAddr)
  );

  function automatic logic [63:0] fuResult(logic [63:0] a, logic [63:0] b, logic [3:0] op);
    return a + b + 64'(op);
  endfunction

  task automatic chkEq(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle();
    issueValid = 1'b0;
    cdbValid   = 1'b0;
    cdbTag     = '0;
  endtask

  task automatic setIssue(input logic [3:0] op, input logic [2:0] rj, input logic [63:0] vj,
                          input logic [2:0] rk, input logic [63:0] vk, input logic [2:0] d,
                          input logic [15:0] addr);
    issueValid = 1'b1; issueOp = op;
    issueRegJ = rj; issueValJ = vj; issueRegK = rk; issueValK = vk;
    issueDest = d; issueAddr = addr;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [63:0] v);
    cdbValid = 1'b1; cdbTag = t; cdbData = v;
  endtask

  task automatic chkDisp(input string req, input int t, input logic [63:0] a, input logic [63:0] b);
    chkEq(req, "dispValid", 64'(dispValid), 64'd1);
    chkEq(req, "dispTag", 64'(dispTag), 64'(t));
    chkEq(req, "dispVj", dispVj, a);
    chkEq(req, "dispVk", dispVk, b);
  endtask

  task automatic doReset();
    idle();
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=expired expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int bc, slot, t, j, k, d, st, sel;
    bit anyFree, accepted, ok;
    logic [3:0]  op;
    logic [15:0] addr;
    logic [63:0] newGold;

    void'($urandom(32'd4242));
    @(negedge clk);
    doReset();

    // R1: reset state
    chkEq("R1", "issueReady", 64'(issueReady), 64'd1);
    chkEq("R1", "dispValid", 64'(dispValid), 64'd0);

    // R3, R2: both sources present, dispatch next cycle from station 1
    setIssue(4'd1, 3'd1, 64'd10, 3'd2, 64'd20, 3'd3, 16'h0100);
    step(); idle();
    chkDisp("R3", 1, 64'd10, 64'd20);
    chkEq("R3", "dispOp", 64'(dispOp), 64'd1);
    chkEq("R3", "dispAddr", 64'(dispAddr), 64'h100);
    step();
    chkEq("R7", "dispValid after single dispatch", 64'(dispValid), 64'd0);

    // R4: reader of renamed r3 waits on tag 1
    setIssue(4'd2, 3'd3, JUNK, 3'd1, 64'd10, 3'd4, 16'h0200);
    step(); idle();
    chkEq("R4", "dispValid waiting", 64'(dispValid), 64'd0);
    setIssue(4'd3, 3'd3, JUNK, 3'd4, JUNK, 3'd3, 16'h0300);
    step(); idle();
    chkEq("R2", "issueReady full", 64'(issueReady), 64'd0);
    setIssue(4'd4, 3'd1, 64'd10, 3'd2, 64'd20, 3'd5, 16'h0400);
    step(); idle();
    chkEq("R2", "issue while full ignored, no dispatch", 64'(dispValid), 64'd0);
    chkEq("R2", "issueReady still low", 64'(issueReady), 64'd0);

    // R5, R8: tag 1 broadcast wakes station 2 and frees station 1
    bcast(4'd1, 64'd77);
    step(); idle();
    chkDisp("R5", 2, 64'd77, 64'd10);
    chkEq("R8", "issueReady after free", 64'(issueReady), 64'd1);

    // R9: r3 still renamed to tag 3; E lands in station 1 while tag 2 broadcasts
    setIssue(4'd5, 3'd3, JUNK, 3'd0, 64'd5, 3'd5, 16'h0500);
    bcast(4'd2, 64'd55);
    step(); idle();
    chkDisp("R5", 3, 64'd77, 64'd55);

    // R6: F reads r3 in the same cycle tag 3 broadcasts
    setIssue(4'd6, 3'd3, JUNK, 3'd3, JUNK, 3'd6, 16'h0600);
    bcast(4'd3, 64'd123);
    step(); idle();
    chkDisp("R9", 1, 64'd123, 64'd5);
    chkEq("R7", "lowest ready first", 64'(dispTag), 64'd1);
    step();
    chkDisp("R6", 2, 64'd123, 64'd123);
    step();
    chkEq("R7", "no repeat dispatch", 64'(dispValid), 64'd0);

    // R10: invalid broadcast or tag 0 captures nothing
    setIssue(4'd7, 3'd6, JUNK, 3'd1, 64'd10, 3'd7, 16'h0700);
    step(); idle();
    cdbValid = 1'b0; cdbTag = 4'd2; cdbData = 64'd9;
    step(); idle();
    chkEq("R10", "valid low ignored", 64'(dispValid), 64'd0);
    cdbValid = 1'b1; cdbTag = 4'd0; cdbData = 64'd9;
    step(); idle();
    chkEq("R10", "tag zero ignored", 64'(dispValid), 64'd0);
    bcast(4'd2, 64'd44);
    step(); idle();
    chkDisp("R5", 3, 64'd44, 64'd10);
    bcast(4'd1, 64'd1);
    step();
    bcast(4'd3, 64'd2);
    step(); idle();
    chkEq("R8", "all free after drain", 64'(issueReady), 64'd1);

    // Random phase from a fresh reset
    doReset();
    for (int r = 0; r < NREG; r++) begin
      rf[r] = {32'($urandom), 32'($urandom)};
      gold[r] = rf[r];
      regWriter[r] = 0;
    end
    for (int s = 0; s <= NRS; s++) begin
      mBusy[s] = 0; mStarted[s] = 0; pend[s] = 0; pendDelay[s] = 0;
    end

    for (int cyc = 0; cyc < RAND_CYCLES + DRAIN; cyc++) begin
      anyFree = 0;
      for (int s = 1; s <= NRS; s++) if (!mBusy[s]) anyFree = 1;
      chkEq("R2", "issueReady vs occupancy", 64'(issueReady), 64'(anyFree));

      for (int s = 1; s <= NRS; s++) if (pend[s] && pendDelay[s] > 0) pendDelay[s]--;

      if (dispValid) begin
        t = int'(dispTag);
        ok = (t >= 1) && (t <= NRS);
        if (ok) ok = mBusy[t] && !mStarted[t];
        chkEq("R7", "dispatch of waiting station", 64'(ok), 64'd1);
        if (ok) begin
          chkEq("R5", "random dispVj", dispVj, expJ[t]);
          chkEq("R5", "random dispVk", dispVk, expK[t]);
          chkEq("R3", "random dispOp", 64'(dispOp), 64'(expOp[t]));
          chkEq("R3", "random dispAddr", 64'(dispAddr), 64'(expAddr[t]));
          mStarted[t] = 1;
          pend[t] = 1;
          pendData[t] = fuResult(dispVj, dispVk, dispOp);
          pendDelay[t] = 1 + int'($urandom % 4);
        end
      end

      bc = 0;
      st = int'($urandom % NRS);
      for (int q = 0; q < NRS; q++) begin
        t = ((st + q) % NRS) + 1;
        if (bc == 0 && pend[t] && pendDelay[t] == 0 && ($urandom % 3) != 0) bc = t;
      end
      if (bc != 0) begin
        bcast(4'(bc), pendData[bc]);
      end else begin
        sel = int'($urandom % 4);
        cdbData = {32'($urandom), 32'($urandom)};
        if (sel == 0) begin cdbValid = 1'b0; cdbTag = 4'(1 + $urandom % NRS); end
        else if (sel == 1) begin cdbValid = 1'b1; cdbTag = 4'd0; end
        else begin cdbValid = 1'b0; cdbTag = 4'd0; end
      end

      accepted = 0;
      slot = 0;
      if (cyc < RAND_CYCLES && ($urandom % 10) < 6) begin
        op = 4'($urandom % 16);
        j = int'($urandom % NREG);
        k = int'($urandom % NREG);
        d = int'($urandom % NREG);
        addr = 16'($urandom);
        setIssue(op, 3'(j), (regWriter[j] != 0) ? JUNK : rf[j],
                 3'(k), (regWriter[k] != 0) ? JUNK : rf[k], 3'(d), addr);
        if (anyFree) begin
          for (int s = NRS; s >= 1; s--) if (!mBusy[s]) slot = s;
          accepted = 1;
          expJ[slot] = gold[j];
          expK[slot] = gold[k];
          expOp[slot] = op;
          expAddr[slot] = addr;
          newGold = fuResult(gold[j], gold[k], op);
          mBusy[slot] = 1;
          mStarted[slot] = 0;
        end
      end else begin
        issueValid = 1'b0;
      end

      if (bc != 0) begin
        mBusy[bc] = 0;
        pend[bc] = 0;
        for (int r = 0; r < NREG; r++) begin
          if (regWriter[r] == bc) begin
            rf[r] = pendData[bc];
            regWriter[r] = 0;
          end
        end
      end
      if (accepted) begin
        gold[d] = newGold;
        regWriter[d] = slot;
      end
      step();
    end
    idle();
    step();

    for (int s = 1; s <= NRS; s++) chkEq("R8", "station drained", 64'(mBusy[s]), 64'd0);
    chkEq("R8", "issueReady at end", 64'(issueReady), 64'd1);
    for (int r = 0; r < NREG; r++) chkEq("R4", "final register value", rf[r], gold[r]);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule